// File: doc/BRIEF.md
# Playback Command Sequencer

This block turns queued playback commands into a stream of memory read addresses, each marked with an end-of-packet flag. A controller places a command on a small input port: stop, play a fixed number of words, or play without end. Commands other than stop go into a command queue. The word count and the start time are captured together with the command. Stop is not queued. It acts at once: it clears the queue and halts any playback in progress.

The sequencer takes one command at a time from the queue. When it takes a command, it loads the window base, window size and packet length from its configuration inputs. A timed command then waits until a free-running tick counter reaches the stored start time. During playback the block emits one address per cycle, starting at the window base. After the last word of the window the address returns to the base. An end-of-packet mark is placed on the last word of every packet, and also on the final word of a finite command. The block reports the free space in the queue and the current tick count.

Top module: `play_sequencer`

## Requirements
- R1: A command is the 32-bit word on `cmd_word` while `cmd_wr` is high. Bits [1:0] give the mode: 0 stop, 1 finite, 2 continuous. Bit 31 set marks the command as timed. Mode 3 is ignored: it changes neither the queue space nor the output.
- R2: A finite command with count N emits exactly N words. Word i has address `base + (i mod size)`, and after the last word `out_valid` falls.
- R3: `out_eop` is high on every word whose index within the command satisfies i mod wpp = wpp-1. It is also high on the final word of a finite command, even when that word ends a short packet.
- R4: After the word at `base + size - 1`, the address returns to `base`. This applies in both the finite and the continuous mode.
- R5: A continuous command emits words with no end until a stop arrives. A word that is valid in the cycle the stop arrives is still emitted, and no word follows it.
- R6: A stop empties the queue, so `fifo_space` returns to DEPTH on the next cycle. It also abandons a command that is waiting for its start time.
- R7: `fifo_space` equals DEPTH minus the number of queued commands. A command taken for playback no longer counts as queued.
- R8: A finite or continuous command written while `fifo_space` is 0 is dropped.
- R9: A timed command whose start time T is still in the future emits its first word in the cycle in which `cur_time` reads T+1.
- R10: A command that is untimed, or timed with a start time already past, emits its first word three cycles after the cycle in which it was written.
- R11: The count and the start time are captured when the command is written. Changes to `cfg_count` or `cfg_time` after that have no effect on the command.
- R12: Commands play in the order they were written. A finite command with count 0 emits nothing.
- R13: In reset, `out_valid` is 0, `fifo_space` is DEPTH and `cur_time` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command strobe |
| cmd_word | input | 32 | Command: mode in [1:0], timed flag in [31] |
| cfg_count | input | CNT_W | Word count for a finite command, captured when the command is written |
| cfg_time | input | TIME_W | Start tick for a timed command, captured when the command is written |
| cfg_base | input | ADDR_W | Window base address, loaded when a command is taken from the queue |
| cfg_size | input | ADDR_W | Window size in words (at least 1) |
| cfg_wpp | input | WPP_W | Words per packet (at least 1) |
| out_valid | output | 1 | A read address is presented this cycle |
| out_addr | output | ADDR_W | Read address, which is also the current play position |
| out_eop | output | 1 | Last word of a packet |
| fifo_space | output | $clog2(DEPTH+1) | Free entries in the command queue |
| cur_time | output | TIME_W | Free-running tick counter |

## Verification
The tests use finite commands whose counts end both on a packet boundary and short of one. Comparing the two separates end-of-packet marks that come from the packet counter from marks that come from the final-word rule. One finite command is longer than its window, and one continuous command is stopped after a chosen number of words, so the wrap to the base is checked in both modes. Three timed cases are compared: a start time in the future, a start time already past, and an untimed command. These show whether the wait compares against the stored time or starts too early or too late. Further tests fill the queue behind a long wait, write one command too many, and issue a stop. These separate dropping from overwriting, and flushing from merely halting. A zero-count command placed between two others checks ordering and skipping.

// File: rtl/play_seq_pkg.sv
package play_seq_pkg;
   typedef enum logic [1:0] {
      MODE_STOP   = 2'd0,
      MODE_FINITE = 2'd1,
      MODE_LOOP   = 2'd2,
      MODE_RSVD   = 2'd3
   } play_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RUN  = 2'd2
   } eng_state_e;

   localparam int CMD_TIMED_BIT = 31;
endpackage

// File: rtl/play_cmd_fifo.sv
module play_cmd_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [WIDTH-1:0]           din,
   input  logic                       pop,
   output logic [WIDTH-1:0]           dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] space
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("play_cmd_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("play_cmd_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             push_ok, pop_ok;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign dout    = mem[rd_q];
   assign space   = CNT_W'(DEPTH) - cnt_q;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_nxt;
         if (pop_ok)  rd_q <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH)); // R7
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R6
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop && !flush) |=> full); // R8
endmodule

// File: rtl/play_engine.sv
module play_engine
   import play_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 64,
   parameter int TIME_W = 64,
   parameter int WPP_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req,
   input  logic [TIME_W-1:0] now,
   input  logic              q_empty,
   input  logic              q_loop,
   input  logic              q_timed,
   input  logic [CNT_W-1:0]  q_count,
   input  logic [TIME_W-1:0] q_start,
   output logic              q_pop,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_size,
   input  logic [WPP_W-1:0]  cfg_wpp,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_eop
);
   eng_state_e        state_q;
   logic              loop_q, timed_q;
   logic [CNT_W-1:0]  remain_q;
   logic [TIME_W-1:0] start_q;
   logic [ADDR_W-1:0] base_q, size_q, ofs_q;
   logic [WPP_W-1:0]  wpp_q, pkt_q;
   logic              pkt_end, cmd_end;

   assign q_pop     = (state_q == ST_IDLE) && !q_empty && !stop_req;
   assign out_valid = (state_q == ST_RUN);
   assign out_addr  = base_q + ofs_q;
   assign pkt_end   = (pkt_q == wpp_q - 1'b1);
   assign cmd_end   = !loop_q && (remain_q == CNT_W'(1));
   assign out_eop   = out_valid && (pkt_end || cmd_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         loop_q   <= 1'b0;
         timed_q  <= 1'b0;
         remain_q <= '0;
         start_q  <= '0;
         base_q   <= '0;
         size_q   <= '0;
         wpp_q    <= '0;
         ofs_q    <= '0;
         pkt_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (q_pop) begin
                  loop_q   <= q_loop;
                  timed_q  <= q_timed;
                  remain_q <= q_count;
                  start_q  <= q_start;
                  base_q   <= cfg_base;
                  size_q   <= cfg_size;
                  wpp_q    <= cfg_wpp;
                  state_q  <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (stop_req || (!loop_q && remain_q == '0)) begin
                  state_q <= ST_IDLE;
               end else if (!timed_q || now >= start_q) begin
                  ofs_q   <= '0;
                  pkt_q   <= '0;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (stop_req || cmd_end) begin
                  state_q <= ST_IDLE;
               end else begin
                  ofs_q    <= (ofs_q == size_q - 1'b1) ? '0 : ofs_q + 1'b1;
                  pkt_q    <= pkt_end ? '0 : pkt_q + 1'b1;
                  remain_q <= remain_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (ADDR_W'(out_addr - base_q) < size_q)); // R4
   AST_TIMED_START: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(out_valid) && timed_q) |-> (now > start_q)); // R9
   AST_FINITE_END: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cmd_end) |=> !out_valid); // R2
endmodule

// File: rtl/play_sequencer.sv
module play_sequencer
   import play_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 64,
   parameter int TIME_W = 64,
   parameter int WPP_W  = 16,
   parameter int DEPTH  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_wr,
   input  logic [31:0]                cmd_word,
   input  logic [CNT_W-1:0]           cfg_count,
   input  logic [TIME_W-1:0]          cfg_time,
   input  logic [ADDR_W-1:0]          cfg_base,
   input  logic [ADDR_W-1:0]          cfg_size,
   input  logic [WPP_W-1:0]           cfg_wpp,
   output logic                       out_valid,
   output logic [ADDR_W-1:0]          out_addr,
   output logic                       out_eop,
   output logic [$clog2(DEPTH+1)-1:0] fifo_space,
   output logic [TIME_W-1:0]          cur_time
);
   localparam int ENTRY_W = 2 + CNT_W + TIME_W;

   generate
      if (ADDR_W < 2 || WPP_W < 1 || CNT_W < 1 || TIME_W < 1) begin : g_bad_width
         $error("play_sequencer: widths out of range");
      end
   endgenerate

   play_mode_e        mode;
   logic              stop_req, push_req;
   logic [ENTRY_W-1:0] wr_entry, rd_entry;
   logic              q_empty, q_full, q_pop;

   assign mode     = play_mode_e'(cmd_word[1:0]);
   assign stop_req = cmd_wr && (mode == MODE_STOP);
   assign push_req = cmd_wr && (mode == MODE_FINITE || mode == MODE_LOOP);
   assign wr_entry = {mode == MODE_LOOP, cmd_word[CMD_TIMED_BIT], cfg_count, cfg_time};

   always_ff @(posedge clk) begin
      if (!rst_n) cur_time <= '0;
      else        cur_time <= cur_time + 1'b1;
   end

   play_cmd_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) cmd_q_i (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (stop_req),
      .push  (push_req),
      .din   (wr_entry),
      .pop   (q_pop),
      .dout  (rd_entry),
      .empty (q_empty),
      .full  (q_full),
      .space (fifo_space)
   );

   play_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TIME_W(TIME_W), .WPP_W(WPP_W)) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_req  (stop_req),
      .now       (cur_time),
      .q_empty   (q_empty),
      .q_loop    (rd_entry[ENTRY_W-1]),
      .q_timed   (rd_entry[ENTRY_W-2]),
      .q_count   (rd_entry[TIME_W +: CNT_W]),
      .q_start   (rd_entry[TIME_W-1:0]),
      .q_pop     (q_pop),
      .cfg_base  (cfg_base),
      .cfg_size  (cfg_size),
      .cfg_wpp   (cfg_wpp),
      .out_valid (out_valid),
      .out_addr  (out_addr),
      .out_eop   (out_eop)
   );

   AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && q_full && !q_pop) |=> (fifo_space == '0)); // R8
endmodule

// File: tb/play_sequencer_tb.sv
module play_sequencer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16, CW = 64, TW = 64, WW = 16, DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr = 1'b0;
   logic [31:0]   cmd_word = '0;
   logic [CW-1:0] cfg_count = '0;
   logic [TW-1:0] cfg_time = '0;
   logic [AW-1:0] cfg_base = '0, cfg_size = 16'd1;
   logic [WW-1:0] cfg_wpp = 16'd1;
   logic          out_valid, out_eop;
   logic [AW-1:0] out_addr;
   logic [2:0]    fifo_space;
   logic [TW-1:0] cur_time;

   int errors = 0, checks = 0;
   logic [AW:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   play_sequencer #(.ADDR_W(AW), .CNT_W(CW), .TIME_W(TW), .WPP_W(WW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
      .cfg_count(cfg_count), .cfg_time(cfg_time), .cfg_base(cfg_base),
      .cfg_size(cfg_size), .cfg_wpp(cfg_wpp), .out_valid(out_valid),
      .out_addr(out_addr), .out_eop(out_eop), .fifo_space(fifo_space),
      .cur_time(cur_time));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: every valid word is compared with the next expected {eop,addr}
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 R5 R6 R8 R12 unexpected word, addr", longint'(out_addr), -1);
         end else begin
            logic [AW:0] e;
            e = exp_q.pop_front();
            check(out_addr == e[AW-1:0], "R2 R4 address", longint'(out_addr), longint'(e[AW-1:0]));
            check(out_eop == e[AW], "R3 end-of-packet", longint'(out_eop), longint'(e[AW]));
         end
      end
   end

   task automatic expect_words(input int base, input int size, input int wpp, input int n, input bit fin);
      for (int i = 0; i < n; i++) begin
         logic eop;
         eop = ((i % wpp) == wpp - 1) || (fin && i == n - 1);
         exp_q.push_back({eop, AW'(base + (i % size))});
      end
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk);
      cmd_word = w;
      cmd_wr   = 1'b1;
      @(negedge clk);
      cmd_wr   = 1'b0;
   endtask

   task automatic drain(input int limit);
      for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      longint t0, tt;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R13 valid in reset", longint'(out_valid), 0);
      check(fifo_space == 3'(DEPTH), "R13 space in reset", longint'(fifo_space), DEPTH);
      check(cur_time == '0, "R13 time in reset", longint'(cur_time), 0);
      rst_n = 1'b1;

      // R2 R3: finite command, short final packet
      cfg_base = 100; cfg_size = 16; cfg_wpp = 4; cfg_count = 10;
      expect_words(100, 16, 4, 10, 1'b1);
      send(32'h1);
      drain(100);

      // R4: finite command longer than the window wraps to base
      cfg_base = 200; cfg_size = 8; cfg_wpp = 5; cfg_count = 20;
      expect_words(200, 8, 5, 20, 1'b1);
      send(32'h1);
      drain(100);

      // R1: reserved mode 3 is ignored
      send(32'h3);
      check(fifo_space == 3'(DEPTH), "R1 space after mode 3", longint'(fifo_space), DEPTH);
      repeat (8) @(negedge clk);

      // R5 R6: continuous with stop after 15 words
      cfg_base = 50; cfg_size = 6; cfg_wpp = 4;
      expect_words(50, 6, 4, 15, 1'b0);
      @(negedge clk); cmd_word = 32'h2; cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) begin
         @(negedge clk); #1;
      end
      cmd_word = 32'h0; cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R5 continuous words left", exp_q.size(), 0);
      check(fifo_space == 3'(DEPTH), "R6 space after stop", longint'(fifo_space), DEPTH);

      // R9: timed start in the future
      cfg_base = 10; cfg_size = 16; cfg_wpp = 4; cfg_count = 3;
      @(negedge clk);
      tt = longint'(cur_time) + 30;
      cfg_time = TW'(tt);
      expect_words(10, 16, 4, 3, 1'b1);
      send(32'h8000_0001);
      for (int i = 0; i < 100 && !out_valid; i++) @(negedge clk);
      check(longint'(cur_time) == tt + 1, "R9 first word time", longint'(cur_time), tt + 1);
      drain(50);

      // R10: timed with past start, and untimed, both start three cycles after the write
      cfg_time = 5;
      expect_words(10, 16, 4, 3, 1'b1);
      @(negedge clk); t0 = longint'(cur_time); cmd_word = 32'h8000_0001; cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
      for (int i = 0; i < 50 && !out_valid; i++) @(negedge clk);
      check(longint'(cur_time) == t0 + 3, "R10 past-time latency", longint'(cur_time), t0 + 3);
      drain(50);
      expect_words(10, 16, 4, 3, 1'b1);
      @(negedge clk); t0 = longint'(cur_time); cmd_word = 32'h1; cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
      for (int i = 0; i < 50 && !out_valid; i++) @(negedge clk);
      check(longint'(cur_time) == t0 + 3, "R10 untimed latency", longint'(cur_time), t0 + 3);
      drain(50);

      // R11: count captured at write
      cfg_count = 5;
      expect_words(10, 16, 4, 5, 1'b1);
      @(negedge clk); cmd_word = 32'h1; cmd_wr = 1'b1;
      @(negedge clk); cmd_wr = 1'b0; cfg_count = 9;
      drain(50);
      check(exp_q.size() == 0, "R11 snapshot count", exp_q.size(), 0);

      // R7 R8 R6: fill the queue behind a long wait, overflow, then stop
      @(negedge clk);
      cfg_time = cur_time + 500; cfg_count = 2;
      send(32'h8000_0001);
      repeat (3) @(negedge clk);
      check(fifo_space == 3'(DEPTH), "R7 head taken leaves queue empty", longint'(fifo_space), DEPTH);
      cfg_count = 1;
      for (int k = 1; k <= DEPTH; k++) begin
         send(32'h1);
         check(fifo_space == 3'(DEPTH - k), "R7 space after push", longint'(fifo_space), DEPTH - k);
      end
      send(32'h2);
      check(fifo_space == 3'd0, "R8 space after overflow write", longint'(fifo_space), 0);
      send(32'h0);
      check(fifo_space == 3'(DEPTH), "R6 space after stop flush", longint'(fifo_space), DEPTH);
      repeat (550) @(negedge clk);
      check(out_valid == 1'b0, "R6 no output after stop", longint'(out_valid), 0);

      // R12: order, zero-count skipped
      cfg_base = 300; cfg_size = 16; cfg_wpp = 4;
      cfg_count = 0; send(32'h1);
      cfg_count = 2; expect_words(300, 16, 4, 2, 1'b1); send(32'h1);
      cfg_count = 3; expect_words(300, 16, 4, 3, 1'b1); send(32'h1);
      drain(100);
      check(exp_q.size() == 0, "R12 all queued words seen", exp_q.size(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule